// File: doc/BRIEF.md
# Register Initialization Command Sequencer

The sequencer brings a device's register space into a known state by walking a list of initialization commands. Software, or a boot controller, first fills two local tables through load ports: a command table and a shared data-word table. It then pulses `start` with a half-open range of command indices. The block runs each command in that range as word writes on one of two outputs. The first is a valid/ready register write bus. The second is a mailbox port that carries indirect writes as an address phase followed by a data phase.

Every command holds four fields: an opcode, a target byte address, a length in 32-bit words, and an argument. The argument is the write value for single writes and an index into the data table for all other commands. Zero-fill, bulk copy and swapped copy are cut into bursts of at most `MAX_BURST` words, and `bus_last` marks the end of each burst. A fill or copy longer than the staging limit is refused, and so is an opcode the block does not know. Each raises a sticky error flag and the walk goes on with the next command. A one-cycle `done` pulse closes the walk.

Top module: `init_seq_top`

## Requirements
- R1: After reset, `bus_valid`, `mbx_valid`, `busy`, `done`, `err_op` and `err_size` are all 0.
- R2: A `start` pulse in the idle state runs commands `start_idx` up to `end_idx`-1, strictly in index order. When `start_idx >= end_idx`, no write happens and only `done` is produced. A `start` while `busy` is ignored.
- R3: Opcode 2 produces one bus write with the target address, the argument as data and `bus_last`=1. Opcode 1 completes without any transaction.
- R4: Opcode 4 with length L produces L bus writes. Write i has address target+4*i, data equal to data-table word (argument+i) mod `DAT_DEPTH`, and `bus_last`=1. L=0 produces nothing.
- R5: Opcodes 3 and 5 use the mailbox port only. Each word takes two handshakes in this order: `mbx_data_ph`=0 with `mbx_word`=target+4*i, then `mbx_data_ph`=1 with the word. For opcode 3 the word is the argument and the length is 1. For opcode 5 the word is the data-table entry, as in R4.
- R6: Opcode 6 writes L all-zero words at target+4*i.
- R7: Opcode 8 copies L data-table words, as in R4, split into bursts. `bus_last` is 1 on word i exactly when (i mod `MAX_BURST`) = `MAX_BURST`-1 or i = L-1.
- R8: Opcode 7 behaves like opcode 8, except that each word is byte-reversed: bits [7:0] go to [31:24], bits [15:8] go to [23:16], and so on.
- R9: An opcode 6, 7 or 8 command with L > `STAGE_WORDS` makes no write and sets `err_size`. L = `STAGE_WORDS` is accepted. The walk continues with the next command.
- R10: Opcodes 0 and 9 to 15 make no write and set `err_op`. The walk continues.
- R11: While `bus_valid` (or `mbx_valid`) is 1 and the matching ready is 0, the valid signal and its address, data, last and phase outputs stay unchanged.
- R12: `done` is high for exactly one cycle after the last command's final handshake, and `busy` is 0 from then on. `err_op` and `err_size` hold until the next accepted `start`, which clears them.
- R13: Table load strobes that arrive while `busy` is 1 have no effect on either table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a walk (accepted only when idle) |
| start_idx | input | CMD_EW | First command index |
| end_idx | input | CMD_EW | One past the last command index |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle end-of-walk pulse |
| err_op | output | 1 | Sticky: unknown opcode seen |
| err_size | output | 1 | Sticky: oversized fill or copy refused |
| cmd_ld_en | input | 1 | Command table write strobe |
| cmd_ld_idx | input | CMD_AW | Command table slot |
| cmd_ld_op | input | 4 | Opcode to store |
| cmd_ld_addr | input | ADDR_W | Target byte address to store |
| cmd_ld_len | input | LEN_W | Length in words to store |
| cmd_ld_arg | input | 32 | Value or data-table index to store |
| dat_ld_en | input | 1 | Data table write strobe |
| dat_ld_idx | input | DAT_AW | Data table slot |
| dat_ld_word | input | 32 | Data word to store |
| bus_valid | output | 1 | Register write request |
| bus_ready | input | 1 | Register write accepted |
| bus_addr | output | ADDR_W | Byte address of the write |
| bus_data | output | 32 | Write data |
| bus_last | output | 1 | Final word of the current burst |
| mbx_valid | output | 1 | Mailbox phase request |
| mbx_ready | input | 1 | Mailbox phase accepted |
| mbx_data_ph | output | 1 | 0 = address phase, 1 = data phase |
| mbx_word | output | 32 | Address or data of the phase |

## Verification
The hardest situation to reach is a burst boundary that falls while the bus is stalled. Near it sit the lengths just below and above the staging limit, and the case where a refused command lies between two good ones, so that the walk has to resume cleanly. The stimulus fills the command table from a fixed-seed random source. It biases copy lengths toward multiples of the burst size and toward the 60-to-69 band around the limit, and it drops ready at random rates. Directed runs add exact lengths of 1, 8, 17, 64 and 65, empty and reversed ranges, and load or start strobes issued in the middle of a walk.

// File: rtl/init_seq_pkg.sv
package init_seq_pkg;

  localparam logic [3:0] OPC_RD   = 4'd1;
  localparam logic [3:0] OPC_WR   = 4'd2;
  localparam logic [3:0] OPC_IWR  = 4'd3;
  localparam logic [3:0] OPC_STR  = 4'd4;
  localparam logic [3:0] OPC_ISTR = 4'd5;
  localparam logic [3:0] OPC_ZERO = 4'd6;
  localparam logic [3:0] OPC_SWAP = 4'd7;
  localparam logic [3:0] OPC_BULK = 4'd8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DECODE,
    ST_BUS,
    ST_MBX_A,
    ST_MBX_D
  } seq_state_e;

  function automatic logic [31:0] byte_rev(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  function automatic logic is_chunked(input logic [3:0] op);
    return (op == OPC_ZERO) || (op == OPC_SWAP) || (op == OPC_BULK);
  endfunction

endpackage

// File: rtl/init_seq_rf.sv
module init_seq_rf #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_idx,
  input  logic [WIDTH-1:0] wr_data,
  input  logic [AW-1:0]    rd_idx,
  output logic [WIDTH-1:0] rd_data
);

  logic [WIDTH-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem_q[wr_idx] <= wr_data;
    end
  end

  assign rd_data = mem_q[rd_idx];

endmodule

// File: rtl/init_seq_engine.sv
module init_seq_engine
  import init_seq_pkg::*;
#(
  parameter int ADDR_W      = 20,
  parameter int LEN_W       = 8,
  parameter int CMD_DEPTH   = 16,
  parameter int DAT_DEPTH   = 128,
  parameter int MAX_BURST   = 8,
  parameter int STAGE_WORDS = 64,
  localparam int CMD_AW = $clog2(CMD_DEPTH),
  localparam int CMD_EW = $clog2(CMD_DEPTH + 1),
  localparam int DAT_AW = $clog2(DAT_DEPTH),
  localparam int BC_W   = $clog2(MAX_BURST + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CMD_EW-1:0] start_idx,
  input  logic [CMD_EW-1:0] end_idx,
  output logic [CMD_AW-1:0] cmd_rd_idx,
  input  logic [3:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [LEN_W-1:0]  cmd_len,
  input  logic [31:0]       cmd_arg,
  output logic [DAT_AW-1:0] dat_rd_idx,
  input  logic [31:0]       dat_rd_word,
  output logic              bus_valid,
  input  logic              bus_ready,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [31:0]       bus_data,
  output logic              bus_last,
  output logic              mbx_valid,
  input  logic              mbx_ready,
  output logic              mbx_data_ph,
  output logic [31:0]       mbx_word,
  output logic              busy,
  output logic              done,
  output logic              err_op,
  output logic              err_size
);

  seq_state_e        state_q, state_n;
  logic [CMD_EW-1:0] cmd_idx_q, cmd_idx_n;
  logic [CMD_EW-1:0] end_q, end_n;
  logic [3:0]        op_q, op_n;
  logic [ADDR_W-1:0] base_q, base_n;
  logic [LEN_W-1:0]  len_q, len_n;
  logic [31:0]       arg_q, arg_n;
  logic [LEN_W-1:0]  idx_q, idx_n;
  logic [BC_W-1:0]   bcnt_q, bcnt_n;
  logic              bus_valid_q, bus_valid_n;
  logic [ADDR_W-1:0] bus_addr_q, bus_addr_n;
  logic [31:0]       bus_data_q, bus_data_n;
  logic              bus_last_q, bus_last_n;
  logic              mbx_valid_q, mbx_valid_n;
  logic              mbx_ph_q, mbx_ph_n;
  logic [31:0]       mbx_word_q, mbx_word_n;
  logic              done_q, done_n;
  logic              err_op_q, err_op_n;
  logic              err_size_q, err_size_n;

  logic [LEN_W-1:0]  idx_nx;
  logic [BC_W-1:0]   bcnt_nx;
  logic [ADDR_W-1:0] addr_nx;
  logic              upd_en;

  // data-table read pointer: next word while streaming, current word in the mailbox
  always_comb begin
    if (state_q == ST_DECODE) begin
      dat_rd_idx = DAT_AW'(cmd_arg);
    end else begin
      dat_rd_idx = DAT_AW'(arg_q) + DAT_AW'(idx_q) + DAT_AW'(state_q == ST_BUS);
    end
  end

  assign cmd_rd_idx = cmd_idx_q[CMD_AW-1:0];

  function automatic logic [31:0] word_sel(input logic [3:0] op,
                                           input logic [31:0] arg,
                                           input logic [31:0] rdw);
    case (op)
      OPC_WR, OPC_IWR: return arg;
      OPC_ZERO:        return 32'd0;
      OPC_SWAP:        return byte_rev(rdw);
      default:         return rdw;
    endcase
  endfunction

  assign idx_nx  = idx_q + 1'b1;
  assign addr_nx = base_q + ADDR_W'({idx_nx, 2'b00});
  assign bcnt_nx = (bcnt_q == BC_W'(MAX_BURST - 1)) ? '0 : bcnt_q + 1'b1;

  always_comb begin
    state_n     = state_q;
    cmd_idx_n   = cmd_idx_q;
    end_n       = end_q;
    op_n        = op_q;
    base_n      = base_q;
    len_n       = len_q;
    arg_n       = arg_q;
    idx_n       = idx_q;
    bcnt_n      = bcnt_q;
    bus_valid_n = bus_valid_q;
    bus_addr_n  = bus_addr_q;
    bus_data_n  = bus_data_q;
    bus_last_n  = bus_last_q;
    mbx_valid_n = mbx_valid_q;
    mbx_ph_n    = mbx_ph_q;
    mbx_word_n  = mbx_word_q;
    err_op_n    = err_op_q;
    err_size_n  = err_size_q;
    done_n      = 1'b0;

    case (state_q)
      ST_IDLE: begin
        if (start) begin
          cmd_idx_n  = start_idx;
          end_n      = end_idx;
          err_op_n   = 1'b0;
          err_size_n = 1'b0;
          state_n    = ST_DECODE;
        end
      end

      ST_DECODE: begin
        if (cmd_idx_q >= end_q) begin
          done_n  = 1'b1;
          state_n = ST_IDLE;
        end else begin
          cmd_idx_n = cmd_idx_q + 1'b1;
          op_n      = cmd_op;
          base_n    = cmd_addr;
          len_n     = cmd_len;
          arg_n     = cmd_arg;
          idx_n     = '0;
          bcnt_n    = '0;
          case (cmd_op)
            OPC_RD: ;
            OPC_WR, OPC_STR: begin
              if (cmd_op == OPC_WR || cmd_len != '0) begin
                if (cmd_op == OPC_WR) len_n = LEN_W'(1);
                bus_valid_n = 1'b1;
                bus_addr_n  = cmd_addr;
                bus_data_n  = word_sel(cmd_op, cmd_arg, dat_rd_word);
                bus_last_n  = 1'b1;
                state_n     = ST_BUS;
              end
            end
            OPC_IWR, OPC_ISTR: begin
              if (cmd_op == OPC_IWR || cmd_len != '0) begin
                if (cmd_op == OPC_IWR) len_n = LEN_W'(1);
                mbx_valid_n = 1'b1;
                mbx_ph_n    = 1'b0;
                mbx_word_n  = 32'(cmd_addr);
                state_n     = ST_MBX_A;
              end
            end
            OPC_ZERO, OPC_SWAP, OPC_BULK: begin
              if (32'(cmd_len) > 32'(STAGE_WORDS)) begin
                err_size_n = 1'b1;
              end else if (cmd_len != '0) begin
                bus_valid_n = 1'b1;
                bus_addr_n  = cmd_addr;
                bus_data_n  = word_sel(cmd_op, cmd_arg, dat_rd_word);
                bus_last_n  = (cmd_len == LEN_W'(1)) || (MAX_BURST == 1);
                state_n     = ST_BUS;
              end
            end
            default: err_op_n = 1'b1;
          endcase
        end
      end

      ST_BUS: begin
        if (bus_ready) begin
          if (idx_nx == len_q) begin
            bus_valid_n = 1'b0;
            bus_last_n  = 1'b0;
            state_n     = ST_DECODE;
          end else begin
            idx_n      = idx_nx;
            bus_addr_n = addr_nx;
            bus_data_n = word_sel(op_q, arg_q, dat_rd_word);
            if (is_chunked(op_q)) begin
              bcnt_n     = bcnt_nx;
              bus_last_n = (bcnt_nx == BC_W'(MAX_BURST - 1)) ||
                           (idx_nx == len_q - 1'b1);
            end else begin
              bus_last_n = 1'b1;
            end
          end
        end
      end

      ST_MBX_A: begin
        if (mbx_ready) begin
          mbx_ph_n   = 1'b1;
          mbx_word_n = word_sel(op_q, arg_q, dat_rd_word);
          state_n    = ST_MBX_D;
        end
      end

      ST_MBX_D: begin
        if (mbx_ready) begin
          if (idx_nx == len_q) begin
            mbx_valid_n = 1'b0;
            mbx_ph_n    = 1'b0;
            state_n     = ST_DECODE;
          end else begin
            idx_n      = idx_nx;
            mbx_ph_n   = 1'b0;
            mbx_word_n = 32'(addr_nx);
            state_n    = ST_MBX_A;
          end
        end
      end

      default: state_n = ST_IDLE;
    endcase
  end

  // datapath registers only move while a walk is active or being launched
  assign upd_en = start || (state_q != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      bus_valid_q <= 1'b0;
      mbx_valid_q <= 1'b0;
      done_q      <= 1'b0;
      err_op_q    <= 1'b0;
      err_size_q  <= 1'b0;
      cmd_idx_q   <= '0;
      end_q       <= '0;
      op_q        <= '0;
      base_q      <= '0;
      len_q       <= '0;
      arg_q       <= '0;
      idx_q       <= '0;
      bcnt_q      <= '0;
      bus_addr_q  <= '0;
      bus_data_q  <= '0;
      bus_last_q  <= 1'b0;
      mbx_ph_q    <= 1'b0;
      mbx_word_q  <= '0;
    end else begin
      done_q <= done_n;
      if (upd_en) begin
        state_q     <= state_n;
        bus_valid_q <= bus_valid_n;
        mbx_valid_q <= mbx_valid_n;
        err_op_q    <= err_op_n;
        err_size_q  <= err_size_n;
        cmd_idx_q   <= cmd_idx_n;
        end_q       <= end_n;
        op_q        <= op_n;
        base_q      <= base_n;
        len_q       <= len_n;
        arg_q       <= arg_n;
        idx_q       <= idx_n;
        bcnt_q      <= bcnt_n;
        bus_addr_q  <= bus_addr_n;
        bus_data_q  <= bus_data_n;
        bus_last_q  <= bus_last_n;
        mbx_ph_q    <= mbx_ph_n;
        mbx_word_q  <= mbx_word_n;
      end
    end
  end

  assign bus_valid   = bus_valid_q;
  assign bus_addr    = bus_addr_q;
  assign bus_data    = bus_data_q;
  assign bus_last    = bus_last_q;
  assign mbx_valid   = mbx_valid_q;
  assign mbx_data_ph = mbx_ph_q;
  assign mbx_word    = mbx_word_q;
  assign busy        = (state_q != ST_IDLE);
  assign done        = done_q;
  assign err_op      = err_op_q;
  assign err_size    = err_size_q;

  // R11: stalled bus request keeps its payload
  p_bus_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid_q && !bus_ready |=> bus_valid_q && $stable(bus_addr_q) &&
    $stable(bus_data_q) && $stable(bus_last_q));

  // R11: stalled mailbox phase keeps its payload
  p_mbx_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mbx_valid_q && !mbx_ready |=> mbx_valid_q && $stable(mbx_ph_q) &&
    $stable(mbx_word_q));

  // R5: an accepted address phase is followed by a data phase
  p_mbx_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mbx_valid_q && mbx_ready && !mbx_ph_q |=> mbx_valid_q && mbx_ph_q);

  // R5: the two write ports never request together
  p_one_port_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_valid_q && mbx_valid_q));

  // R12: done is a single-cycle pulse and the walk is over
  p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !busy && !bus_valid_q && !mbx_valid_q ##1 !done_q);

  // R6: zero-fill words carry no set bit
  p_zero_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid_q && (op_q == OPC_ZERO) |-> bus_data_q == 32'd0);

  // R9: a refused oversize command issues no request
  p_size_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_size_q) |-> !bus_valid_q && !mbx_valid_q);

  // R10: a refused opcode issues no request
  p_op_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_op_q) |-> !bus_valid_q && !mbx_valid_q);

endmodule

// File: rtl/init_seq_top.sv
module init_seq_top #(
  parameter int ADDR_W      = 20,
  parameter int LEN_W       = 8,
  parameter int CMD_DEPTH   = 16,
  parameter int DAT_DEPTH   = 128,
  parameter int MAX_BURST   = 8,
  parameter int STAGE_WORDS = 64,
  localparam int CMD_AW = $clog2(CMD_DEPTH),
  localparam int CMD_EW = $clog2(CMD_DEPTH + 1),
  localparam int DAT_AW = $clog2(DAT_DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CMD_EW-1:0] start_idx,
  input  logic [CMD_EW-1:0] end_idx,
  output logic              busy,
  output logic              done,
  output logic              err_op,
  output logic              err_size,
  input  logic              cmd_ld_en,
  input  logic [CMD_AW-1:0] cmd_ld_idx,
  input  logic [3:0]        cmd_ld_op,
  input  logic [ADDR_W-1:0] cmd_ld_addr,
  input  logic [LEN_W-1:0]  cmd_ld_len,
  input  logic [31:0]       cmd_ld_arg,
  input  logic              dat_ld_en,
  input  logic [DAT_AW-1:0] dat_ld_idx,
  input  logic [31:0]       dat_ld_word,
  output logic              bus_valid,
  input  logic              bus_ready,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [31:0]       bus_data,
  output logic              bus_last,
  output logic              mbx_valid,
  input  logic              mbx_ready,
  output logic              mbx_data_ph,
  output logic [31:0]       mbx_word
);

  localparam int CMD_W = 4 + ADDR_W + LEN_W + 32;

  logic [CMD_AW-1:0] cmd_rd_idx;
  logic [CMD_W-1:0]  cmd_rd_word;
  logic [DAT_AW-1:0] dat_rd_idx;
  logic [31:0]       dat_rd_word;
  logic [3:0]        cmd_op;
  logic [ADDR_W-1:0] cmd_addr;
  logic [LEN_W-1:0]  cmd_len;
  logic [31:0]       cmd_arg;

  // R13: tables are frozen while a walk runs
  init_seq_rf #(.WIDTH(CMD_W), .DEPTH(CMD_DEPTH)) cmd_tab_i (
    .clk     (clk),
    .wr_en   (cmd_ld_en && !busy),
    .wr_idx  (cmd_ld_idx),
    .wr_data ({cmd_ld_op, cmd_ld_addr, cmd_ld_len, cmd_ld_arg}),
    .rd_idx  (cmd_rd_idx),
    .rd_data (cmd_rd_word)
  );

  init_seq_rf #(.WIDTH(32), .DEPTH(DAT_DEPTH)) dat_tab_i (
    .clk     (clk),
    .wr_en   (dat_ld_en && !busy),
    .wr_idx  (dat_ld_idx),
    .wr_data (dat_ld_word),
    .rd_idx  (dat_rd_idx),
    .rd_data (dat_rd_word)
  );

  assign {cmd_op, cmd_addr, cmd_len, cmd_arg} = cmd_rd_word;

  init_seq_engine #(
    .ADDR_W      (ADDR_W),
    .LEN_W       (LEN_W),
    .CMD_DEPTH   (CMD_DEPTH),
    .DAT_DEPTH   (DAT_DEPTH),
    .MAX_BURST   (MAX_BURST),
    .STAGE_WORDS (STAGE_WORDS)
  ) engine_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .start_idx   (start_idx),
    .end_idx     (end_idx),
    .cmd_rd_idx  (cmd_rd_idx),
    .cmd_op      (cmd_op),
    .cmd_addr    (cmd_addr),
    .cmd_len     (cmd_len),
    .cmd_arg     (cmd_arg),
    .dat_rd_idx  (dat_rd_idx),
    .dat_rd_word (dat_rd_word),
    .bus_valid   (bus_valid),
    .bus_ready   (bus_ready),
    .bus_addr    (bus_addr),
    .bus_data    (bus_data),
    .bus_last    (bus_last),
    .mbx_valid   (mbx_valid),
    .mbx_ready   (mbx_ready),
    .mbx_data_ph (mbx_data_ph),
    .mbx_word    (mbx_word),
    .busy        (busy),
    .done        (done),
    .err_op      (err_op),
    .err_size    (err_size)
  );

endmodule

// File: tb/init_seq_top_tb_top.sv
`timescale 1ns/1ps
module init_seq_top_tb_top;

  localparam int ADDR_W = 20;
  localparam int LEN_W  = 8;
  localparam int NCMD   = 16;
  localparam int NDAT   = 128;
  localparam int MAXB   = 8;
  localparam int STAGE  = 64;
  localparam logic [ADDR_W-1:0] AMASK = '1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [4:0] start_idx = '0, end_idx = '0;
  logic busy, done, err_op, err_size;
  logic cmd_ld_en = 1'b0;
  logic [3:0] cmd_ld_idx = '0;
  logic [3:0] cmd_ld_op = '0;
  logic [ADDR_W-1:0] cmd_ld_addr = '0;
  logic [LEN_W-1:0] cmd_ld_len = '0;
  logic [31:0] cmd_ld_arg = '0;
  logic dat_ld_en = 1'b0;
  logic [6:0] dat_ld_idx = '0;
  logic [31:0] dat_ld_word = '0;
  logic bus_valid, bus_ready, bus_last;
  logic [ADDR_W-1:0] bus_addr;
  logic [31:0] bus_data;
  logic mbx_valid, mbx_ready, mbx_data_ph;
  logic [31:0] mbx_word;

  always #2.5 clk = ~clk;

  init_seq_top dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .start_idx(start_idx), .end_idx(end_idx),
    .busy(busy), .done(done), .err_op(err_op), .err_size(err_size),
    .cmd_ld_en(cmd_ld_en), .cmd_ld_idx(cmd_ld_idx), .cmd_ld_op(cmd_ld_op),
    .cmd_ld_addr(cmd_ld_addr), .cmd_ld_len(cmd_ld_len), .cmd_ld_arg(cmd_ld_arg),
    .dat_ld_en(dat_ld_en), .dat_ld_idx(dat_ld_idx), .dat_ld_word(dat_ld_word),
    .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_addr(bus_addr),
    .bus_data(bus_data), .bus_last(bus_last),
    .mbx_valid(mbx_valid), .mbx_ready(mbx_ready), .mbx_data_ph(mbx_data_ph),
    .mbx_word(mbx_word)
  );

  int checks = 0;
  int fails  = 0;
  int rdy_pct = 100;
  bit finished = 1'b0;

  // bench copy of the tables
  logic [3:0]        m_op   [NCMD];
  logic [ADDR_W-1:0] m_addr [NCMD];
  logic [LEN_W-1:0]  m_len  [NCMD];
  logic [31:0]       m_arg  [NCMD];
  logic [31:0]       m_dat  [NDAT];

  // expected and observed traffic
  logic [ADDR_W-1:0] eb_addr[$]; logic [31:0] eb_data[$]; logic eb_last[$]; string eb_req[$];
  logic em_ph[$]; logic [31:0] em_word[$]; string em_req[$];
  logic [ADDR_W-1:0] ob_addr[$]; logic [31:0] ob_data[$]; logic ob_last[$];
  logic om_ph[$]; logic [31:0] om_word[$];
  bit exp_eop, exp_esz;
  int done_cnt = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // ready drivers move just after the active edge
  always @(posedge clk) begin
    #1;
    bus_ready = (($urandom % 100) < rdy_pct);
    mbx_ready = (($urandom % 100) < rdy_pct);
  end

  // monitor: records handshakes and checks R11 hold-while-stalled
  logic pb_stall = 1'b0, pm_stall = 1'b0;
  logic [ADDR_W-1:0] pb_addr; logic [31:0] pb_data; logic pb_last;
  logic pm_ph; logic [31:0] pm_word;
  always @(negedge clk) begin
    if (rst_n) begin
      if (pb_stall) begin
        chk(bus_valid && bus_addr == pb_addr && bus_data == pb_data && bus_last == pb_last,
            "R11", "bus hold", {bus_addr, bus_data}, {pb_addr, pb_data});
      end
      if (pm_stall) begin
        chk(mbx_valid && mbx_data_ph == pm_ph && mbx_word == pm_word,
            "R11", "mailbox hold", {mbx_data_ph, mbx_word}, {pm_ph, pm_word});
      end
      pb_stall = bus_valid && !bus_ready;
      pb_addr = bus_addr; pb_data = bus_data; pb_last = bus_last;
      pm_stall = mbx_valid && !mbx_ready;
      pm_ph = mbx_data_ph; pm_word = mbx_word;
      if (bus_valid && bus_ready) begin
        ob_addr.push_back(bus_addr); ob_data.push_back(bus_data); ob_last.push_back(bus_last);
      end
      if (mbx_valid && mbx_ready) begin
        om_ph.push_back(mbx_data_ph); om_word.push_back(mbx_word);
      end
      if (done) done_cnt++;
    end
  end

  function automatic logic [31:0] brev(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  task automatic set_cmd(input int i, input logic [3:0] op, input logic [ADDR_W-1:0] a,
                         input logic [LEN_W-1:0] l, input logic [31:0] g);
    m_op[i] = op; m_addr[i] = a; m_len[i] = l; m_arg[i] = g;
    @(negedge clk);
    cmd_ld_en = 1'b1; cmd_ld_idx = 4'(i); cmd_ld_op = op;
    cmd_ld_addr = a; cmd_ld_len = l; cmd_ld_arg = g;
    @(negedge clk);
    cmd_ld_en = 1'b0;
  endtask

  task automatic set_dat(input int i, input logic [31:0] w);
    m_dat[i] = w;
    @(negedge clk);
    dat_ld_en = 1'b1; dat_ld_idx = 7'(i); dat_ld_word = w;
    @(negedge clk);
    dat_ld_en = 1'b0;
  endtask

  task automatic build_exp(input int s, input int e);
    eb_addr.delete(); eb_data.delete(); eb_last.delete(); eb_req.delete();
    em_ph.delete(); em_word.delete(); em_req.delete();
    exp_eop = 1'b0; exp_esz = 1'b0;
    for (int c = s; c < e; c++) begin
      case (m_op[c])
        4'd1: ;
        4'd2: begin
          eb_addr.push_back(m_addr[c]); eb_data.push_back(m_arg[c]);
          eb_last.push_back(1'b1); eb_req.push_back("R3");
        end
        4'd4: for (int i = 0; i < int'(m_len[c]); i++) begin
          eb_addr.push_back((m_addr[c] + ADDR_W'(4 * i)) & AMASK);
          eb_data.push_back(m_dat[(m_arg[c] + i) % NDAT]);
          eb_last.push_back(1'b1); eb_req.push_back("R4");
        end
        4'd3: begin
          em_ph.push_back(1'b0); em_word.push_back(32'(m_addr[c])); em_req.push_back("R5");
          em_ph.push_back(1'b1); em_word.push_back(m_arg[c]); em_req.push_back("R5");
        end
        4'd5: for (int i = 0; i < int'(m_len[c]); i++) begin
          em_ph.push_back(1'b0);
          em_word.push_back(32'((m_addr[c] + ADDR_W'(4 * i)) & AMASK));
          em_req.push_back("R5");
          em_ph.push_back(1'b1); em_word.push_back(m_dat[(m_arg[c] + i) % NDAT]);
          em_req.push_back("R5");
        end
        4'd6, 4'd7, 4'd8: begin
          if (int'(m_len[c]) > STAGE) exp_esz = 1'b1;
          else for (int i = 0; i < int'(m_len[c]); i++) begin
            logic [31:0] w;
            w = m_dat[(m_arg[c] + i) % NDAT];
            eb_addr.push_back((m_addr[c] + ADDR_W'(4 * i)) & AMASK);
            eb_data.push_back(m_op[c] == 4'd6 ? 32'd0 : (m_op[c] == 4'd7 ? brev(w) : w));
            eb_last.push_back(((i % MAXB) == MAXB - 1) || (i == int'(m_len[c]) - 1));
            eb_req.push_back(m_op[c] == 4'd6 ? "R6" : (m_op[c] == 4'd7 ? "R8" : "R7"));
          end
        end
        default: exp_eop = 1'b1;
      endcase
    end
  endtask

  task automatic run_range(input int s, input int e, input bit poke);
    int n;
    build_exp(s, e);
    ob_addr.delete(); ob_data.delete(); ob_last.delete();
    om_ph.delete(); om_word.delete();
    done_cnt = 0;
    @(negedge clk);
    start = 1'b1; start_idx = 5'(s); end_idx = 5'(e);
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (3) @(negedge clk);
      chk(busy == 1'b1, "R2", "busy mid-walk", 64'(busy), 64'd1);
      // stray start and loads while busy
      start = 1'b1; start_idx = 5'd0; end_idx = 5'd1;
      cmd_ld_en = 1'b1; cmd_ld_idx = 4'd0; cmd_ld_op = 4'd2;
      cmd_ld_addr = 20'h0BAD0; cmd_ld_len = 8'd1; cmd_ld_arg = 32'hDEAD_BEEF;
      dat_ld_en = 1'b1; dat_ld_idx = 7'd0; dat_ld_word = 32'hFFFF_0000;
      @(negedge clk);
      start = 1'b0; cmd_ld_en = 1'b0; dat_ld_en = 1'b0;
    end
    n = 0;
    while (!done && n < 30000) begin
      @(negedge clk);
      n++;
    end
    repeat (2) @(negedge clk);
    chk(n < 30000, "R12", "walk finished", 64'(n), 64'd30000);
    chk(done_cnt == 1, "R12", "done pulse count", 64'(done_cnt), 64'd1);
    chk(!busy && !done, "R12", "idle after done", {busy, done}, 64'd0);
    chk(err_op == exp_eop, "R10", "err_op flag", 64'(err_op), 64'(exp_eop));
    chk(err_size == exp_esz, "R9", "err_size flag", 64'(err_size), 64'(exp_esz));
    chk(ob_addr.size() == eb_addr.size(), "R2", "bus write count",
        64'(ob_addr.size()), 64'(eb_addr.size()));
    chk(om_ph.size() == em_ph.size(), "R5", "mailbox phase count",
        64'(om_ph.size()), 64'(em_ph.size()));
    for (int i = 0; i < eb_addr.size() && i < ob_addr.size(); i++) begin
      chk(ob_addr[i] == eb_addr[i] && ob_data[i] == eb_data[i] && ob_last[i] == eb_last[i],
          eb_req[i], $sformatf("bus beat %0d {addr,data,last}", i),
          {3'b0, ob_addr[i], ob_data[i], ob_last[i]}, {3'b0, eb_addr[i], eb_data[i], eb_last[i]});
    end
    for (int i = 0; i < em_ph.size() && i < om_ph.size(); i++) begin
      chk(om_ph[i] == em_ph[i] && om_word[i] == em_word[i], em_req[i],
          $sformatf("mailbox phase %0d {ph,word}", i),
          {om_ph[i], om_word[i]}, {em_ph[i], em_word[i]});
    end
  endtask

  task automatic rand_tables();
    for (int c = 0; c < NCMD; c++) begin
      int r;
      logic [3:0] op;
      logic [LEN_W-1:0] l;
      r = $urandom % 20;
      if (r < 2) op = (r == 0) ? 4'd0 : 4'(9 + $urandom % 7);
      else op = 4'((r % 8) + 1);
      if (op >= 4'd6 && op <= 4'd8) begin
        case ($urandom % 5)
          0: l = LEN_W'(60 + $urandom % 10);
          1: l = LEN_W'(MAXB * (1 + $urandom % 3));
          default: l = LEN_W'($urandom % 24);
        endcase
      end else begin
        l = LEN_W'($urandom % 12);
      end
      set_cmd(c, op, ADDR_W'($urandom) & 20'hFFFFC, l, $urandom);
    end
    for (int d = 0; d < NDAT; d++) set_dat(d, $urandom);
  endtask

  initial begin
    int seed;
    seed = $urandom(32'd20240611);
    bus_ready = 1'b1; mbx_ready = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!bus_valid && !mbx_valid, "R1", "valids in reset", {bus_valid, mbx_valid}, 64'd0);
    chk(!busy && !done && !err_op && !err_size, "R1", "status in reset",
        {busy, done, err_op, err_size}, 64'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy && !bus_valid && !mbx_valid, "R1", "idle after reset",
        {busy, bus_valid, mbx_valid}, 64'd0);

    for (int d = 0; d < NDAT; d++) set_dat(d, 32'h1000_0000 + 32'(d * 32'h0104_0201));

    // directed: one of each opcode (R3..R8)
    set_cmd(0, 4'd2, 20'h00100, 8'd0, 32'hA5A5_0001);
    set_cmd(1, 4'd1, 20'h00200, 8'd3, 32'd0);
    set_cmd(2, 4'd4, 20'h00300, 8'd3, 32'd126);
    set_cmd(3, 4'd3, 20'h00400, 8'd5, 32'h1234_5678);
    set_cmd(4, 4'd5, 20'h00500, 8'd2, 32'd7);
    set_cmd(5, 4'd6, 20'h00600, 8'd17, 32'd0);
    set_cmd(6, 4'd8, 20'h00700, 8'd8, 32'd9);
    set_cmd(7, 4'd7, 20'h00800, 8'd10, 32'd40);
    set_cmd(8, 4'd4, 20'h00900, 8'd0, 32'd0);
    set_cmd(9, 4'd8, 20'h00A00, 8'd1, 32'd3);
    rdy_pct = 100;
    run_range(0, 10, 1'b0);
    rdy_pct = 40;
    run_range(0, 10, 1'b0);

    // directed: staging limit edge and a bad opcode between good commands (R9, R10)
    set_cmd(10, 4'd8, 20'h01000, 8'd64, 32'd0);
    set_cmd(11, 4'd6, 20'h02000, 8'd65, 32'd0);
    set_cmd(12, 4'd9, 20'h03000, 8'd4, 32'd0);
    set_cmd(13, 4'd2, 20'h04000, 8'd0, 32'hCAFE_F00D);
    set_cmd(14, 4'd0, 20'h05000, 8'd1, 32'd0);
    set_cmd(15, 4'd7, 20'h06000, 8'd66, 32'd0);
    rdy_pct = 70;
    run_range(10, 16, 1'b0);
    run_range(11, 12, 1'b0);
    run_range(12, 13, 1'b0);

    // R2: empty and reversed ranges
    run_range(5, 5, 1'b0);
    run_range(9, 3, 1'b0);

    // R2/R13: start and loads while busy are ignored
    set_cmd(0, 4'd2, 20'h00100, 8'd0, 32'h0000_C0DE);
    rdy_pct = 30;
    run_range(5, 8, 1'b1);
    run_range(0, 1, 1'b0);
    chk(ob_data.size() == 1 && ob_data[0] == 32'h0000_C0DE && ob_addr[0] == 20'h00100,
        "R13", "command slot kept", 64'(ob_data.size() > 0 ? ob_data[0] : 32'd0), 64'h0000_C0DE);
    set_cmd(1, 4'd4, 20'h00140, 8'd1, 32'd0);
    run_range(1, 2, 1'b0);
    chk(ob_data.size() == 1 && ob_data[0] == m_dat[0], "R13", "data slot kept",
        64'(ob_data.size() > 0 ? ob_data[0] : 32'd0), 64'(m_dat[0]));

    // constrained random rounds
    for (int round = 0; round < 12; round++) begin
      int s, e;
      rand_tables();
      rdy_pct = 25 + int'($urandom % 76);
      s = int'($urandom % 4);
      e = 12 + int'($urandom % 5);
      run_range(s, e, 1'b0);
    end

    finished = 1'b1;
    report();
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not finish actual=%0d expected=%0d", 150000, 0);
      report();
    end
  end

endmodule